// File: doc/BRIEF.md
# Bank-Gated 4K x 4 Synchronous RAM

This block is a 4096-word, 4-bit synchronous memory with one write port and one read port sharing a clock. In its default arrangement the storage is split into four banks of 1024 words, each as wide as the full word. The two top address bits choose the bank, and only that bank receives a clock enable on an access. The other three banks stay idle, which removes most of the array switching activity on every cycle.

Each port's access enable is turned into the clock enable of the bank it touches. That derived enable is then ANDed with the port's own user clock enable. A read takes one cycle. The bank select used by the read-data multiplexer is registered next to the banks' output registers, so it stays aligned with the data. When no read takes place, the output keeps its last value.

A parameter chooses a comparison arrangement instead: four 4096 x 1 banks, one per data bit, all clocked on every access. The decoded per-bank clock enables are brought out as ports so that the gating can be observed.

Top module: `sliced_ram`

## Requirements
- R1: A word written at any of the 4096 addresses is returned on `rdData` at the first falling clock edge after the rising edge that samples a read of that address, so the read latency is one cycle.
- R2: In the default arrangement, address bits [11:10] select the bank and bits [9:0] select the word within it. Words that share the low ten bits but differ in bits [11:10] are stored independently.
- R3: In the default arrangement, a write that is enabled raises only `bankWrCe[k]`, where k = `wrAddr[11:10]`. A read that is enabled raises only `bankRdCe[k]`, where k = `rdAddr[11:10]`. At most one bit of each vector is ever high.
- R4: While `wrEn` is 0, `bankWrCe` is 0 and no memory word changes. While `rdEn` is 0, `bankRdCe` is 0.
- R5: Each port's clock enable is its access enable ANDed with its user clock enable. With `wrUserCe` at 0 a write does not take effect. With `rdUserCe` at 0 a read does not take effect, and `rdData` keeps its previous value.
- R6: The bank select for the read-data multiplexer is registered when a read is taken. In back-to-back reads to different banks, each output word comes from the bank addressed one cycle earlier.
- R7: When the same address is written and read in the same cycle, the read returns the data stored before that write.
- R8: In a cycle with no effective read, `rdData` does not change.
- R9: After reset, `rdData` is 0 until the first read.
- R10: With the vertical arrangement selected (`SLICE = SLICE_VERT`), every write raises all four bits of `bankWrCe`, every read raises all four bits of `bankRdCe`, and data is returned exactly as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low reset of the output and select registers |
| wrAddr | input | 12 | Write address |
| wrData | input | 4 | Write data |
| wrEn | input | 1 | Write enable |
| wrUserCe | input | 1 | User clock enable of the write port (tie high if unused) |
| rdAddr | input | 12 | Read address |
| rdEn | input | 1 | Read enable |
| rdUserCe | input | 1 | User clock enable of the read port (tie high if unused) |
| rdData | output | 4 | Read data, one cycle after the read |
| bankWrCe | output | 4 | Decoded per-bank write clock enables |
| bankRdCe | output | 4 | Decoded per-bank read clock enables |

## Verification
The hardest case to reach from the ports is one where the registered multiplexer select and the bank output registers could drift apart. This happens when back-to-back reads go to different banks, or when a suppressed read changes the address, because a stale or early select would quietly return another bank's word. The stimulus first fills words that share their low address bits across all four banks with distinct values. It then issues consecutive reads that hop between banks, and reads masked by `rdUserCe` or `rdEn` with a new address on the bus. A simultaneous write and read of one address checks that the old word is returned.

// File: rtl/sliced_ram_pkg.sv
package sliced_ram_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BSEL_W = $clog2(NUM_BANKS);

  typedef enum logic {SLICE_HORIZ, SLICE_VERT} slice_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] wrCe;
    logic [NUM_BANKS-1:0] rdCe;
    logic [BSEL_W-1:0]    rdSelQ;
  } ramStrobe_t;
endpackage

// File: rtl/sliced_ram_ctrl.sv
module sliced_ram_ctrl
  import sliced_ram_pkg::*;
#(
  parameter slice_e SLICE = SLICE_HORIZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSEL_W-1:0] wrAddrHi,
  input  logic              wrEn,
  input  logic              wrUserCe,
  input  logic [BSEL_W-1:0] rdAddrHi,
  input  logic              rdEn,
  input  logic              rdUserCe,
  output ramStrobe_t        strobe
);
  logic wrGo, rdGo;
  logic [BSEL_W-1:0] rdSelQ;

  // access enable converted to clock enable, combined with user enable
  assign wrGo = wrEn & wrUserCe;
  assign rdGo = rdEn & rdUserCe;

  generate
    if (SLICE == SLICE_HORIZ) begin : g_decode
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        assign strobe.wrCe[k] = wrGo && (wrAddrHi == BSEL_W'(k));
        assign strobe.rdCe[k] = rdGo && (rdAddrHi == BSEL_W'(k));
      end
      a_r3_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe.wrCe));
      a_r3_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe.rdCe));
      a_r2_wr_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wrEn && wrUserCe) |-> strobe.wrCe[wrAddrHi]);
    end else begin : g_all
      assign strobe.wrCe = {NUM_BANKS{wrGo}};
      assign strobe.rdCe = {NUM_BANKS{rdGo}};
      a_r10_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (wrEn && wrUserCe) |-> (strobe.wrCe == {NUM_BANKS{1'b1}}));
    end
  endgenerate

  // mux select registered alongside the bank output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdSelQ <= '0;
    else if (rdGo) rdSelQ <= rdAddrHi;
  end
  assign strobe.rdSelQ = rdSelQ;

  a_r4_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (strobe.wrCe == '0));
  a_r4_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> (strobe.rdCe == '0));
  a_r5_user_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrUserCe |-> (strobe.wrCe == '0)) and (!rdUserCe |-> (strobe.rdCe == '0)));
  a_r6_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdUserCe) |=> (strobe.rdSelQ == $past(rdAddrHi)));
endmodule

// File: rtl/sliced_ram_datapath.sv
module sliced_ram_datapath
  import sliced_ram_pkg::*;
#(
  parameter int     ADDR_W  = 12,
  parameter int     DATA_W  = 4,
  parameter slice_e SLICE   = SLICE_HORIZ,
  parameter int     BANK_AW = ADDR_W - BSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ramStrobe_t         strobe,
  input  logic [BANK_AW-1:0] wrOff,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BANK_AW-1:0] rdOff,
  output logic [DATA_W-1:0]  rdData
);
  localparam int DEPTH = 1 << BANK_AW;

  generate
    if (SLICE == SLICE_HORIZ) begin : g_horiz
      logic [DATA_W-1:0] bankQ [NUM_BANKS];
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
          if (strobe.wrCe[k]) mem[wrOff] <= wrData;
        end
        // read register samples the pre-write word on a collision
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)              bankQ[k] <= '0;
          else if (strobe.rdCe[k]) bankQ[k] <= mem[rdOff];
        end
      end
      assign rdData = bankQ[strobe.rdSelQ];
    end else begin : g_vert
      logic [DATA_W-1:0] bitQ;
      for (genvar b = 0; b < DATA_W; b++) begin : g_bank
        logic mem [DEPTH];
        always_ff @(posedge clk) begin
          if (strobe.wrCe[b % NUM_BANKS]) mem[wrOff] <= wrData[b];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                          bitQ[b] <= 1'b0;
          else if (strobe.rdCe[b % NUM_BANKS]) bitQ[b] <= mem[rdOff];
        end
      end
      assign rdData = bitQ;
    end
  endgenerate

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdCe == '0) |=> $stable(rdData));
endmodule

// File: rtl/sliced_ram.sv
module sliced_ram
  import sliced_ram_pkg::*;
#(
  parameter int     ADDR_W = 12,
  parameter int     DATA_W = 4,
  parameter slice_e SLICE  = SLICE_HORIZ
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrEn,
  input  logic                 wrUserCe,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 rdEn,
  input  logic                 rdUserCe,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_BANKS-1:0] bankWrCe,
  output logic [NUM_BANKS-1:0] bankRdCe
);
  localparam int OFF_W   = ADDR_W - BSEL_W;
  localparam int BANK_AW = (SLICE == SLICE_HORIZ) ? OFF_W : ADDR_W;

  ramStrobe_t strobe;

  sliced_ram_ctrl #(.SLICE(SLICE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrAddrHi (wrAddr[ADDR_W-1:OFF_W]),
    .wrEn     (wrEn),
    .wrUserCe (wrUserCe),
    .rdAddrHi (rdAddr[ADDR_W-1:OFF_W]),
    .rdEn     (rdEn),
    .rdUserCe (rdUserCe),
    .strobe   (strobe)
  );

  sliced_ram_datapath #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SLICE (SLICE), .BANK_AW (BANK_AW)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrOff  (wrAddr[BANK_AW-1:0]),
    .wrData (wrData),
    .rdOff  (rdAddr[BANK_AW-1:0]),
    .rdData (rdData)
  );

  assign bankWrCe = strobe.wrCe;
  assign bankRdCe = strobe.rdCe;
endmodule

// File: tb/sliced_ram_test.sv
module sliced_ram_test;
  import sliced_ram_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] wrAddr = '0, rdAddr = '0;
  logic [3:0]  wrData = '0;
  logic wrEn = 1'b0, wrUserCe = 1'b1, rdEn = 1'b0, rdUserCe = 1'b1;
  logic [3:0] rdData, bankWrCe, bankRdCe;
  logic [3:0] vRdData, vWrCe, vRdCe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk; // 250 MHz

  sliced_ram #(.SLICE(SLICE_HORIZ)) uut (
    .clk(clk), .rst_n(rst_n), .wrAddr(wrAddr), .wrData(wrData), .wrEn(wrEn),
    .wrUserCe(wrUserCe), .rdAddr(rdAddr), .rdEn(rdEn), .rdUserCe(rdUserCe),
    .rdData(rdData), .bankWrCe(bankWrCe), .bankRdCe(bankRdCe));

  sliced_ram #(.SLICE(SLICE_VERT)) uutVert (
    .clk(clk), .rst_n(rst_n), .wrAddr(wrAddr), .wrData(wrData), .wrEn(wrEn),
    .wrUserCe(wrUserCe), .rdAddr(rdAddr), .rdEn(rdEn), .rdUserCe(rdUserCe),
    .rdData(vRdData), .bankWrCe(vWrCe), .bankRdCe(vRdCe));

  // {address, data}; addresses share low bits across banks
  localparam logic [15:0] VEC [8] = '{
    {12'h000, 4'h1}, {12'h400, 4'h2}, {12'h800, 4'h3}, {12'hC00, 4'h4},
    {12'h3FF, 4'h5}, {12'h7FF, 4'h6}, {12'hABC, 4'h7}, {12'hFFF, 4'h8}};

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] dec(input logic [11:0] a);
    return 4'b0001 << a[11:10];
  endfunction

  // drive at falling edge, peek enables, release at next falling edge
  task automatic doWrite(input logic [11:0] a, input logic [3:0] d, input logic en,
                         input logic uce, input logic [3:0] expCe);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = en; wrUserCe = uce;
    #1;
    chk("R3/R4/R5 write ce", bankWrCe, expCe);
    @(negedge clk);
    wrEn = 1'b0; wrUserCe = 1'b1;
  endtask

  task automatic doRead(input logic [11:0] a, input logic uce, input logic [3:0] expData,
                        input string req);
    @(negedge clk);
    rdAddr = a; rdEn = 1'b1; rdUserCe = uce;
    @(negedge clk);
    rdEn = 1'b0; rdUserCe = 1'b1;
    chk(req, rdData, expData);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset rdData", rdData, 4'h0);
    chk("R9 reset rdData vert", vRdData, 4'h0);

    // table walk: fill, then read back
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wrAddr = VEC[i][15:4]; wrData = VEC[i][3:0]; wrEn = 1'b1;
      #1;
      chk("R3 one bank write ce", bankWrCe, dec(VEC[i][15:4]));
      chk("R10 vertical write ce", vWrCe, 4'hF);
    end
    @(negedge clk) wrEn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rdAddr = VEC[i][15:4]; rdEn = 1'b1;
      #1;
      chk("R3 one bank read ce", bankRdCe, dec(VEC[i][15:4]));
      chk("R10 vertical read ce", vRdCe, 4'hF);
      @(negedge clk);
      rdEn = 1'b0;
      chk("R1/R2 readback", rdData, VEC[i][3:0]);
      chk("R10 vertical readback", vRdData, VEC[i][3:0]);
    end

    // R4: write with wrEn low does not land
    doWrite(12'h000, 4'hF, 1'b0, 1'b1, 4'h0);
    doRead(12'h000, 1'b1, 4'h1, "R4 no write without wrEn");
    // R5: user clock enable low masks write
    doWrite(12'h400, 4'hF, 1'b1, 1'b0, 4'h0);
    doRead(12'h400, 1'b1, 4'h2, "R5 write masked by user ce");
    // R5: masked read holds output
    doRead(12'h000, 1'b1, 4'h1, "R1 read bank0");
    @(negedge clk);
    rdAddr = 12'hFFF; rdEn = 1'b1; rdUserCe = 1'b0;
    #1;
    chk("R5 read ce masked", bankRdCe, 4'h0);
    @(negedge clk);
    rdEn = 1'b0; rdUserCe = 1'b1;
    chk("R5 masked read holds", rdData, 4'h1);
    // R8: no read while address moves
    @(negedge clk) rdAddr = 12'hC00;
    #1;
    chk("R4 no read ce without rdEn", bankRdCe, 4'h0);
    @(negedge clk);
    chk("R8 idle hold", rdData, 4'h1);

    // R6: back-to-back reads hopping across banks
    @(negedge clk); rdAddr = 12'h800; rdEn = 1'b1;
    @(negedge clk); rdAddr = 12'h000;
    chk("R6 b2b first", rdData, 4'h3);
    @(negedge clk); rdAddr = 12'hC00;
    chk("R6 b2b second", rdData, 4'h1);
    @(negedge clk); rdEn = 1'b0; rdAddr = 12'h400;
    chk("R6 b2b third", rdData, 4'h4);
    @(negedge clk);
    chk("R6 select held after reads", rdData, 4'h4);

    // R7: collision returns old word, then the new one
    @(negedge clk);
    wrAddr = 12'hABC; wrData = 4'h9; wrEn = 1'b1;
    rdAddr = 12'hABC; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R7 collision old data", rdData, 4'h7);
    chk("R7 collision old data vert", vRdData, 4'h7);
    doRead(12'hABC, 1'b1, 4'h9, "R7 new data after collision");
    chk("R10 vertical new data", vRdData, 4'h9);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule